// File: doc/BRIEF.md
# TDM Time-Slot Interchanger

This block switches byte-wide channels between bit-serial TDM lines. Over each frame it stores every incoming channel in a speech memory that has two halves. Writes for the frame now arriving go to one half. Output time slots read from the other half, which holds the last complete frame. A connection memory has one entry for each output channel, and that entry names the stored input channel to send. A host loads the connection memory over a byte-wide write port, one connection per three-byte sequence.

A single device clock runs the block. The output lines always run at the slow rate, with four clocks per bit. The input lines run at the same slow rate, or at the fast rate of one clock per bit, where four lines carry four times as many slots. Both rates store 512 channels in a frame of 1024 clocks. A sync pulse marks the frame: its rising edge starts the input frame and its falling edge places the output frame. The pulse width therefore sets the input-to-output offset in steps of four clocks.

Top module: `tdm_slot_switch`

## Requirements
- R1: After reset no output channel is connected, and every output line stays at 1.
- R2: A connection is written by three byte writes (`wr_stb` high with `cs_n` low). Byte 1 carries the source channel bit 8 in bit 0 and the destination channel bit 8 in bit 1. Byte 2 carries source bits 7:0. Byte 3 carries destination bits 7:0. The connection takes effect only on the third byte, and the next byte then starts a new sequence.
- R3: While `cs_n` is high the byte counter returns to zero, so a sequence that was cut off is dropped without changing any connection.
- R4: An output channel that has never been connected sends 8'hFF.
- R5: Slow input: all 16 input lines carry 32 slots of 8 bits, MSB first, at 4 clocks per bit. The first clock on which `sync_in` is sampled high is position 0 of the input frame. Channel number = slot*16 + line.
- R6: Fast input (`in_fast`=1): only input lines 12 to 15 are used, at 1 clock per bit with 128 slots. Logical line = physical line mod 4, and channel number = slot*4 + logical line. The other input lines are ignored.
- R7: Output: 16 lines carry 32 slots at 4 clocks per bit, MSB first. Output channel number = slot*16 + line, and each bit holds for 4 clocks.
- R8: `sync_in` is high for 2+4N clocks (N from 0 to 255). Output frame position 0 falls 2 clocks before the first clock on which `sync_in` is sampled low, so the output frame lags the input frame by 4N clocks.
- R9: An output slot sends the byte that the connected input channel carried in the input frame before the one in progress when the slot starts. With N=0 this is a delay of exactly one frame.
- R10: Any input channel can be connected to any output channel, and one input channel can feed several outputs at once.
- R11: Writing a connection to a destination that is already connected replaces the old source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_fast | input | 1 | Selects the fast input rate |
| sync_in | input | 1 | Frame sync pulse |
| cs_n | input | 1 | Write port select, active low |
| wr_stb | input | 1 | Byte write strobe |
| wr_data | input | 8 | Programming byte |
| tdm_in | input | 16 | Serial input lines |
| tdm_out | output | 16 | Serial output lines |

## Verification
The assertions check the following on every cycle:
- the input and output frame counters are realigned on the sync edges,
- the speech memory halves swap at each input frame start and at no other time,
- the byte counter never leaves its three states and clears whenever the port is deselected,
- the output bits hold steady between 4-clock boundaries.

Only the bench's scenarios can show the switching itself. These scenarios cover which byte reaches which output slot, the one-frame delay, broadcast and replacement, the idle pattern, the fast-line folding, aborted sequences and the output offset for several pulse widths. The bench checks all of these against a model of the connection table and of the per-frame input data.

// File: rtl/tdm_slot_switch.sv
module tdm_slot_switch #(
  parameter int LINES      = 16,
  parameter int SLOTS      = 32,
  parameter int FAST_LINES = 4,
  parameter int BIT_CLKS   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_fast,
  input  logic             sync_in,
  input  logic             cs_n,
  input  logic             wr_stb,
  input  logic [7:0]       wr_data,
  input  logic [LINES-1:0] tdm_in,
  output logic [LINES-1:0] tdm_out
);
  localparam int LW        = $clog2(LINES);
  localparam int SW        = $clog2(SLOTS);
  localparam int AW        = LW + SW;
  localparam int CH        = 1 << AW;
  localparam int FW        = $clog2(FAST_LINES);
  localparam int BCW       = $clog2(BIT_CLKS);
  localparam int PW        = SW + 3 + BCW;
  localparam int FAST_BASE = LINES - FAST_LINES;
  localparam int MID       = BIT_CLKS / 2;

  logic          sp_q, bank;
  logic [PW-1:0] icnt, ocnt;

  wire rise = sync_in & ~sp_q;
  wire fall = ~sync_in & sp_q;
  wire [PW-1:0] ipos  = rise ? '0 : icnt;
  wire [PW-1:0] opos  = fall ? PW'(2) : ocnt;
  wire          wbank = rise ? ~bank : bank;
  wire [SW-1:0] oslot = opos[PW-1:BCW+3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= 1'b0;
      bank <= 1'b0;
      icnt <= '0;
      ocnt <= '0;
    end else begin
      sp_q <= sync_in;
      icnt <= ipos + 1'b1;
      ocnt <= opos + 1'b1;
      if (rise) bank <= ~bank;
    end
  end

  logic [7:0] sm  [2*CH];
  logic [7:0] ish [LINES];

  always_ff @(posedge clk) begin
    if (in_fast) begin
      for (int l = 0; l < FAST_LINES; l++) begin
        ish[l] <= {ish[l][6:0], tdm_in[FAST_BASE+l]};
        if (ipos[2:0] == 3'd7)
          sm[{wbank, ipos[PW-1:3], FW'(l)}] <= {ish[l][6:0], tdm_in[FAST_BASE+l]};
      end
    end else if (ipos[BCW-1:0] == BCW'(MID)) begin
      for (int l = 0; l < LINES; l++) begin
        ish[l] <= {ish[l][6:0], tdm_in[l]};
        if (ipos[BCW+2:BCW] == 3'd7)
          sm[{wbank, ipos[PW-1:BCW+3], LW'(l)}] <= {ish[l][6:0], tdm_in[l]};
      end
    end
  end

  logic [1:0]    bcnt, hi;
  logic [7:0]    src_lo;
  logic [CH-1:0] cm_vld;
  logic [AW-1:0] cm_src [CH];

  wire          cm_we  = ~cs_n & wr_stb & (bcnt == 2'd2);
  wire [AW-1:0] cm_dst = {hi[1], wr_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt   <= '0;
      hi     <= '0;
      src_lo <= '0;
      cm_vld <= '0;
    end else if (cs_n) begin
      bcnt <= '0;
    end else if (wr_stb) begin
      case (bcnt)
        2'd0:    begin hi <= wr_data[1:0]; bcnt <= 2'd1; end
        2'd1:    begin src_lo <= wr_data; bcnt <= 2'd2; end
        default: begin cm_vld[cm_dst] <= 1'b1; bcnt <= 2'd0; end
      endcase
    end
  end

  always_ff @(posedge clk)
    if (cm_we) cm_src[cm_dst] <= {hi[0], src_lo};

  logic [7:0] obyte [LINES];
  logic [7:0] osh   [LINES];

  always_comb
    for (int l = 0; l < LINES; l++)
      obyte[l] = cm_vld[{oslot, LW'(l)}] ? sm[{~wbank, cm_src[{oslot, LW'(l)}]}] : 8'hFF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < LINES; l++) osh[l] <= '1;
    end else begin
      for (int l = 0; l < LINES; l++)
        if (opos[BCW+2:0] == '0)      osh[l] <= obyte[l];
        else if (opos[BCW-1:0] == '0) osh[l] <= {osh[l][6:0], 1'b1};
    end
  end

  always_comb
    for (int l = 0; l < LINES; l++) tdm_out[l] = osh[l][7];

endmodule

// File: rtl/tdm_slot_switch_chk.sv
module tdm_slot_switch_chk #(
  parameter int PW    = 10,
  parameter int BCW   = 2,
  parameter int LINES = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_in,
  input logic             sp_q,
  input logic             cs_n,
  input logic [1:0]       bcnt,
  input logic [PW-1:0]    icnt,
  input logic [PW-1:0]    ocnt,
  input logic             bank,
  input logic [LINES-1:0] tdm_out
);
  wire rise_c = sync_in & ~sp_q;
  wire fall_c = ~sync_in & sp_q;

  AST_COUNT_BOUNDED:   assert property (@(posedge clk) disable iff (!rst_n) bcnt != 2'd3); // R2
  AST_CS_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n) cs_n |=> bcnt == 2'd0); // R3
  AST_IN_FRAME_START:  assert property (@(posedge clk) disable iff (!rst_n) rise_c |=> icnt == PW'(1)); // R5
  AST_OUT_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n) fall_c |=> ocnt == PW'(3)); // R8
  AST_BANK_SWAP:       assert property (@(posedge clk) disable iff (!rst_n) rise_c |=> bank != $past(bank)); // R9
  AST_BANK_HOLD:       assert property (@(posedge clk) disable iff (!rst_n) !rise_c |=> bank == $past(bank)); // R9
  AST_OUT_BIT_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) (!fall_c && ocnt[BCW-1:0] != '0) |=> $stable(tdm_out)); // R7
endmodule

bind tdm_slot_switch tdm_slot_switch_chk #(.PW(PW), .BCW(BCW), .LINES(LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .sp_q(sp_q), .cs_n(cs_n),
  .bcnt(bcnt), .icnt(icnt), .ocnt(ocnt), .bank(bank), .tdm_out(tdm_out)
);

// File: tb/tdm_slot_switch_tb_top.sv
module tdm_slot_switch_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, in_fast, sync_in, cs_n, wr_stb;
  logic [7:0]  wr_data;
  logic [15:0] tdm_in, tdm_out;

  tdm_slot_switch dut_i (
    .clk(clk), .rst_n(rst_n), .in_fast(in_fast), .sync_in(sync_in), .cs_n(cs_n),
    .wr_stb(wr_stb), .wr_data(wr_data), .tdm_in(tdm_in), .tdm_out(tdm_out)
  );

  int    cyc = 0, base = 0, nsp = 0, n_chk = 0, n_fail = 0;
  bit    run = 0, chk_en = 0, armed = 0;
  string req = "R5";
  bit    cmv [512];
  int    cms [512];
  logic [7:0] expq [$];
  logic [7:0] cap  [16];

  always @(posedge clk) cyc++;

  function automatic logic [7:0] pat(int g, int ch);
    return 8'((ch & 255) ^ ((ch >> 8) * 165) ^ (g * 59));
  endfunction

  // input driver: R5 slow layout, R6 fast layout on lines 12..15
  always @(negedge clk) if (run) begin
    int rel, q, k;
    logic [15:0] v;
    rel = cyc + 1 - base;
    q = rel % 1024;
    k = rel / 1024;
    sync_in = (q < 2 + 4 * nsp);
    v = '1;
    if (in_fast) begin
      for (int l = 0; l < 4; l++) v[12+l] = pat(k, (q / 8) * 4 + l)[7 - (q % 8)];
    end else begin
      for (int l = 0; l < 16; l++) v[l] = pat(k, (q / 32) * 16 + l)[7 - ((q / 4) % 8)];
    end
    tdm_in = v;
  end

  // scoreboard: push expected bytes at output slot start, pop after 8 bits (R7, R8, R9)
  always @(negedge clk) if (run && cyc >= base) begin
    int relE, p, s, k;
    logic [7:0] e;
    relE = cyc - base;
    p = ((relE - 4 * nsp) % 1024 + 1024) % 1024;
    s = p / 32;
    k = relE / 1024;
    if (p % 32 == 0) begin
      armed = chk_en;
      if (chk_en)
        for (int l = 0; l < 16; l++)
          expq.push_back(cmv[s*16+l] ? pat(k - 1, cms[s*16+l]) : 8'hFF);
    end
    if (p % 4 == 0)
      for (int l = 0; l < 16; l++) cap[l] = {cap[l][6:0], tdm_out[l]};
    if (p % 32 == 28 && armed) begin
      for (int l = 0; l < 16; l++) begin
        e = expq.pop_front();
        n_chk++;
        if (cap[l] !== e) begin
          n_fail++;
          $display("FAIL %s out line %0d slot %0d%s: got %02h expected %02h",
                   req, l, s, cmv[s*16+l] ? "" : " (idle, R4)", cap[l], e);
        end
      end
      armed = 0;
    end
  end

  task automatic chk_pins(string r, logic [15:0] exp);
    n_chk++;
    if (tdm_out !== exp) begin
      n_fail++;
      $display("FAIL %s tdm_out: got %04h expected %04h", r, tdm_out, exp);
    end
  endtask

  task automatic send_byte(logic [7:0] b);
    @(negedge clk); wr_data = b; wr_stb = 1'b1;
    @(negedge clk); wr_stb = 1'b0;
  endtask

  // R2 byte layout
  task automatic prog(int src, int dst);
    @(negedge clk); cs_n = 1'b0;
    send_byte({6'b0, 1'(dst >> 8), 1'(src >> 8)});
    send_byte(8'(src));
    send_byte(8'(dst));
    @(negedge clk); cs_n = 1'b1;
    cmv[dst] = 1'b1;
    cms[dst] = src;
  endtask

  task automatic run_check(string r);
    req = r;
    repeat (2048) @(posedge clk);
    #1 chk_en = 1;
    repeat (2048) @(posedge clk);
    #1 chk_en = 0;
    repeat (40) @(posedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 0; in_fast = 0; sync_in = 0; cs_n = 1; wr_stb = 0; wr_data = 0; tdm_in = 0;
    repeat (3) @(posedge clk);
    #1 chk_pins("R1", 16'hFFFF);
    rst_n = 1;
    repeat (6) @(posedge clk);
    #1 chk_pins("R1", 16'hFFFF);
    base = cyc + 1;
    run = 1;

    // R5 / R10: mixed connections, one source broadcast
    prog(0, 0);
    prog(511, 55);
    prog(82, 511);
    prog(82, 160);
    prog(329, 300);
    run_check("R5/R7/R9/R10");

    // R2: two bytes held with select low must not connect yet
    @(negedge clk); cs_n = 1'b0;
    send_byte(8'h00);
    send_byte(8'd77);
    run_check("R2");
    send_byte(8'd200);
    @(negedge clk); cs_n = 1'b1;
    cmv[200] = 1'b1; cms[200] = 77;
    run_check("R2");

    // R3: aborted sequence, then R11 replacement
    @(negedge clk); cs_n = 1'b0;
    send_byte(8'h00);
    send_byte(8'd78);
    @(negedge clk); cs_n = 1'b1;
    prog(79, 202);
    prog(33, 55);
    run_check("R3/R11");

    // R8: wider sync pulses shift the output frame
    @(posedge clk); #1 nsp = 5;
    run_check("R8");
    @(posedge clk); #1 nsp = 255;
    run_check("R8");

    // R6: fast input lines fold to logical 0..3
    @(posedge clk); #1 nsp = 1; in_fast = 1;
    prog(7 * 4 + 2, 6 * 16 + 5);
    prog(100 * 4 + 0, 31 * 16 + 0);
    prog(127 * 4 + 3, 1 * 16 + 14);
    run_check("R6");

    @(posedge clk); #1 nsp = 0; in_fast = 0;
    run_check("R5/R9");

    summary();
    $finish;
  end
endmodule